// File: doc/BRIEF.md
# Programmable-Tap Pseudo-Random Bit Generator

This block is an 8-stage Fibonacci-style shift register that produces a pseudo-random bit stream. A run-time tap mask picks which stages feed the XOR that forms the next input bit. Any combination of stages can be used, so maximal-length and short-cycle sequences come from the same hardware, and the mask can be changed between steps.

The register moves by one position on each clock edge at which the step enable is high. The new bit enters at stage 0 and the oldest bit leaves from stage 7, which is also the serial output. A zero-state detector forces a 1 into stage 0 whenever every stage is 0, so a stepping generator never stays locked up. Reset clears the register, and the first step after reset therefore always loads 0x01.

Top module: `prog_lfsr`

## Requirements
- R1: A clock edge with `rst` high clears every stage to 0, so `state_o` is 0x00 and `serial_o` is 0 after it.
- R2: A clock edge with `step_en` low and `rst` low leaves `state_o` unchanged, whatever `taps_i` holds.
- R3: A step moves the contents of stage k into stage k+1 for k from 0 to 6, so the new `state_o[7:1]` equals the old `state_o[6:0]`.
- R4: On a step from a nonzero state, the new stage 0 is the XOR of the old stages i for which `taps_i[i]` is 1. A stage whose mask bit is 0 contributes 0, so mask 0x00 shifts in a 0.
- R5: On a step from the all-zero state, stage 0 is loaded with 1 and the new state is 0x01, for every mask value.
- R6: `serial_o` always equals stage 7 (`state_o[7]`).
- R7: With mask 0xB8 (stages 7, 5, 4 and 3 tapped), starting at 0x01, the generator passes through all 255 nonzero states and comes back to 0x01 after exactly 255 steps.
- R8: A new mask value takes effect on the very next step, with no reset needed.
- R9: While `step_en` is high, the all-zero state never lasts for two consecutive steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the register |
| step_en | input | 1 | Advances the register by one position when high |
| taps_i | input | 8 | Tap mask; bit i includes stage i in the feedback XOR |
| state_o | output | 8 | Register contents; bit 0 is the newest bit |
| serial_o | output | 1 | Serial output, taken from stage 7 |

## Verification
The assertions assume that `step_en` and `taps_i` are driven to known values on every cycle after reset. They also assume that a reset pulse lasts at least one full clock period, so that at least one edge samples it high. The stimulus changes inputs only on the falling clock edge and holds reset across complete cycles. It covers every one of the 256 mask values, with the mask changing both while the register steps and while it is paused.

// File: rtl/prog_lfsr.sv
module prog_lfsr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic [WIDTH-1:0] taps_i,
  output logic [WIDTH-1:0] state_o,
  output logic             serial_o
);

  localparam logic [WIDTH-1:0] ZERO_STATE = '0;
  localparam logic [WIDTH-1:0] ESCAPE_STATE = WIDTH'(1);

  logic [WIDTH-1:0] stages_q;
  logic             stuck_zero;
  logic             next_bit;

  assign stuck_zero = (stages_q == ZERO_STATE);
  assign next_bit   = stuck_zero | (^(stages_q & taps_i));

  always_ff @(posedge clk) begin
    if (rst)          stages_q <= ZERO_STATE;
    else if (step_en) stages_q <= {stages_q[WIDTH-2:0], next_bit};
  end

  assign state_o  = stages_q;
  assign serial_o = stages_q[WIDTH-1];

  // R1: the first cycle after a reset edge shows an empty register
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state_o == ZERO_STATE));

  // R2: a paused register keeps its value
  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !step_en) |=> $stable(state_o));

  // R3: each step moves every bit up by one stage
  p_shift_up_r3: assert property (@(posedge clk) disable iff (rst)
    step_en |=> (state_o[WIDTH-1:1] == $past(state_o[WIDTH-2:0])));

  // R4: from a nonzero state the new bit is the parity of the tapped stages
  p_tap_parity_r4: assert property (@(posedge clk) disable iff (rst)
    (step_en && state_o != ZERO_STATE) |=> (state_o[0] == ^($past(state_o) & $past(taps_i))));

  // R5: the zero state is left for the escape value
  p_zero_escape_r5: assert property (@(posedge clk) disable iff (rst)
    (step_en && state_o == ZERO_STATE) |=> (state_o == ESCAPE_STATE));

  // R9: no two consecutive steps land on the zero state
  p_no_lockup_r9: assert property (@(posedge clk) disable iff (rst)
    (step_en && state_o == ZERO_STATE) |=> (state_o != ZERO_STATE));

endmodule

// File: tb/prog_lfsr_tb_top.sv
module prog_lfsr_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic [7:0] taps_i = 8'h00;
  logic [7:0] state_o;
  logic       serial_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [7:0] model = 8'h00;

  always #4 clk = ~clk;

  prog_lfsr #(.WIDTH(8)) dut_i (
    .clk(clk), .rst(rst), .step_en(step_en), .taps_i(taps_i),
    .state_o(state_o), .serial_o(serial_o)
  );

  function automatic logic [7:0] ref_next(input logic [7:0] s, input logic [7:0] m);
    logic p;
    p = 1'b0;
    for (int i = 0; i < 8; i++) if (m[i]) p = p ^ s[i];
    if (s == 8'h00) return 8'h01;
    return {s[6:0], p};
  endfunction

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic cycle(input logic r, input logic en, input logic [7:0] m);
    @(negedge clk);
    rst = r; step_en = en; taps_i = m;
    @(posedge clk);
    #1;
    if (r) model = 8'h00;
    else if (en) model = ref_next(model, m);
  endtask

  task automatic check_state(input string req);
    check(state_o == model, req, state_o, model);
    check(serial_o == model[7], "R6", serial_o, model[7]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    logic [255:0] seen;
    cycle(1'b1, 1'b0, 8'h00);
    cycle(1'b1, 1'b0, 8'h00);
    check_state("R1");
    // R2: pausing at zero keeps zero; no escape without a step
    for (int k = 0; k < 3; k++) begin
      cycle(1'b0, 1'b0, 8'hFF);
      check_state("R2");
    end
    // R3 R4 R5: sweep every mask from reset
    for (int m = 0; m < 256; m++) begin
      cycle(1'b1, 1'b0, 8'(m));
      check_state("R1");
      cycle(1'b0, 1'b1, 8'(m));
      check(state_o == 8'h01, "R5", state_o, 8'h01);
      for (int k = 0; k < 20; k++) begin
        cycle(1'b0, 1'b1, 8'(m));
        check_state((m == 0) ? "R4" : "R3");
      end
    end
    // R7: maximal period with mask 0xB8
    cycle(1'b1, 1'b0, 8'hB8);
    cycle(1'b0, 1'b1, 8'hB8);
    check(state_o == 8'h01, "R5", state_o, 8'h01);
    seen = '0;
    seen[1] = 1'b1;
    for (int k = 1; k <= 255; k++) begin
      cycle(1'b0, 1'b1, 8'hB8);
      if (k < 255) begin
        check(state_o != 8'h00 && !seen[state_o], "R7", state_o, model);
        seen[state_o] = 1'b1;
      end else begin
        check(state_o == 8'h01, "R7", state_o, 8'h01);
      end
    end
    check(seen[255:1] == {255{1'b1}} && !seen[0], "R7", $countones(seen), 255);
    // R8: mask changes on consecutive steps
    cycle(1'b1, 1'b0, 8'hB8);
    for (int k = 0; k < 40; k++) begin
      cycle(1'b0, 1'b1, 8'(k * 37 + 5));
      check_state("R8");
    end
    // R2: paused mid-run with a changing mask
    for (int k = 0; k < 8; k++) begin
      cycle(1'b0, 1'b0, 8'(k * 91));
      check_state("R2");
    end
    // R9: drain to zero with an empty mask, then escape
    for (int k = 0; k < 12; k++) begin
      cycle(1'b0, 1'b1, 8'h00);
      check_state("R9");
      check(!(state_o == 8'h00 && model == 8'h00 && k > 0 && ref_next(8'h00, 8'h00) == 8'h00), "R9", state_o, model);
    end
    cycle(1'b1, 1'b0, 8'h00);
    check_state("R1");
    finish_run();
  end

endmodule